// File: doc/BRIEF.md
# Hashed Page Table Lookup Engine

This block translates a virtual page number into a physical page number by walking an inverted page table held in memory. The table has one group of entries per physical page rather than one entry per virtual page. It is sized at four entries per physical page, so that collisions stay rare. A lookup folds the virtual page number into a bucket number, adds the bucket's first entry index to a table base address, and then reads the four entries of that bucket one after another. Each entry carries a valid flag, the virtual page number it maps, and protection bits.

The first valid entry whose stored tag equals the requested page number ends the walk. Its position in the table gives the physical page number: the global entry index divided by four, which is the bucket number. When all four entries fail to match, the engine answers with a page fault. Each response also reports how many entries were read, because every collision costs one more memory read. Requests enter through a valid/ready handshake that is open only while the engine is idle. Memory is reached through a single-outstanding read port: a request with valid/ready, and a response that arrives as a one-cycle valid with data.

Top module: `hpt_walker`

## Requirements
- R1: `req_ready` is high exactly while the engine is idle; after a request is accepted `req_ready` stays low until the lookup has answered, so only one lookup is in flight.
- R2: The first read goes to `req_base + 4*B`, where the bucket `B` is the exclusive-or of the upper and lower halves of the page number (bits 19:10 and 9:0 by default), keeping its low log2(bucket count) bits.
- R3: The walk reads entries 0, 1, 2, 3 of the bucket at consecutive addresses, one memory read per probed entry.
- R4: An entry word is laid out as valid in the top bit (bit 23), tag in bits 22:3 and protection in bits 2:0. On a hit the response has `rsp_fault`=0, `rsp_ppn` = (global entry index)/4, `rsp_prot` = the entry's protection bits and `rsp_probes` = position in bucket + 1.
- R5: When none of the four entries matches, the response has `rsp_fault`=1, `rsp_probes`=4, and `rsp_ppn` and `rsp_prot` both 0.
- R6: The walk stops at the first match: no further memory read is issued for that lookup.
- R7: Every accepted request produces exactly one response, signalled by `rsp_valid` high for a single cycle.
- R8: Once `mem_req_valid` is raised it stays high with an unchanged `mem_req_addr` until `mem_req_ready` accepts it.
- R9: An entry whose valid bit is 0 never matches, even when its tag equals the requested page number.
- R10: After reset `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R11: The page number and table base are captured when the request is accepted; changes on `req_vpn` or `req_base` after that do not affect the lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_vpn | input | VPN_W (20) | Virtual page number to translate |
| req_base | input | ADDR_W (12) | Word address of table entry 0 |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W (12) | Word address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is present this cycle |
| mem_rsp_data | input | 1+VPN_W+PROT_W (24) | Table entry word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | No matching entry: page fault |
| rsp_ppn | output | log2(NBKT) (6) | Physical page number on a hit |
| rsp_prot | output | PROT_W (3) | Protection bits of the matching entry |
| rsp_probes | output | 3 | Entries read for this lookup, 1 to 4 |

## Verification
On every cycle the assertions check the handshake rules: that the engine is busy for exactly one lookup, that read requests hold steady under back-pressure, that the first read goes to the hashed bucket and later reads step by one, that a match ends the walk at once, and that faults and invalid entries lead to a four-read fault answer. The actual translation values, namely the physical page number and protection bits for hits in each bucket position, the number of responses per request, and the claim that input changes after acceptance have no effect, can only be shown by the bench's scenarios. Those scenarios place entries in known table positions and compare the answers.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  // a bucket always holds four consecutive table entries
  localparam int unsigned BUCKET_WAYS = 4;
  localparam int unsigned WAY_W       = $clog2(BUCKET_WAYS);
  localparam int unsigned PROBE_W     = WAY_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_state_e;

endpackage

// File: rtl/hpt_hash.sv
// Bucket selection and address generation for one probe.
module hpt_hash
  import hpt_pkg::*;
#(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned NBKT   = 64,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [VPN_W-1:0]            vpn,
  input  logic [ADDR_W-1:0]           base,
  input  logic [WAY_W-1:0]            way,
  output logic [$clog2(NBKT)-1:0]     bkt,
  output logic [$clog2(NBKT)+WAY_W-1:0] idx,
  output logic [$clog2(NBKT)-1:0]     ppn,
  output logic [ADDR_W-1:0]           addr
);
  localparam int unsigned BKT_W = $clog2(NBKT);
  localparam int unsigned IDX_W = BKT_W + WAY_W;
  localparam int unsigned HALF  = VPN_W / 2;

  // fold the page number: upper half xor lower half, masked to the bucket count
  function automatic logic [BKT_W-1:0] fold_vpn(input logic [VPN_W-1:0] v);
    logic [HALF-1:0] x;
    x = v[VPN_W-1:VPN_W-HALF] ^ v[HALF-1:0];
    return x[BKT_W-1:0];
  endfunction

  // global entry index of a probe
  function automatic logic [IDX_W-1:0] entry_index(input logic [BKT_W-1:0] b,
                                                   input logic [WAY_W-1:0] w);
    return {b, w};
  endfunction

  // physical page number of an entry: index divided by the bucket size
  function automatic logic [BKT_W-1:0] page_of(input logic [IDX_W-1:0] i);
    return i[IDX_W-1:WAY_W];
  endfunction

  always_comb begin
    bkt  = fold_vpn(vpn);
    idx  = entry_index(bkt, way);
    ppn  = page_of(idx);
    addr = base + ADDR_W'(idx);
  end

endmodule

// File: rtl/hpt_match.sv
// Decodes one table entry and compares its tag with the page being resolved.
module hpt_match #(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PROT_W = 3
) (
  input  logic [VPN_W+PROT_W:0] entry,
  input  logic [VPN_W-1:0]      vpn,
  output logic                  ent_valid,
  output logic [PROT_W-1:0]     ent_prot,
  output logic                  hit
);
  localparam int unsigned ENT_W = 1 + VPN_W + PROT_W;

  function automatic logic valid_of(input logic [ENT_W-1:0] e);
    return e[ENT_W-1];
  endfunction

  function automatic logic [VPN_W-1:0] tag_of(input logic [ENT_W-1:0] e);
    return e[ENT_W-2:PROT_W];
  endfunction

  function automatic logic [PROT_W-1:0] prot_of(input logic [ENT_W-1:0] e);
    return e[PROT_W-1:0];
  endfunction

  always_comb begin
    ent_valid = valid_of(entry);
    ent_prot  = prot_of(entry);
    hit       = ent_valid && (tag_of(entry) == vpn);
  end

endmodule

// File: rtl/hpt_ctrl.sv
// Walk sequencer: accepts a request, issues up to four reads, forms the answer.
module hpt_ctrl
  import hpt_pkg::*;
#(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PROT_W = 3,
  parameter int unsigned PPN_W  = 6,
  parameter int unsigned ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [ADDR_W-1:0]  req_base,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic               hit,
  input  logic [PPN_W-1:0]   hit_ppn,
  input  logic [PROT_W-1:0]  hit_prot,
  output logic               req_ready,
  output logic               mem_req_valid,
  output logic [VPN_W-1:0]   vpn_q,
  output logic [ADDR_W-1:0]  base_q,
  output logic [WAY_W-1:0]   way_q,
  output logic               ev_accept,
  output logic               ev_probe_fire,
  output logic               ev_probe_done,
  output logic               ev_last_way,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [PPN_W-1:0]   rsp_ppn,
  output logic [PROT_W-1:0]  rsp_prot,
  output logic [PROBE_W-1:0] rsp_probes
);
  walk_state_e state_q;

  function automatic logic [PROBE_W-1:0] probes_used(input logic [WAY_W-1:0] w);
    return PROBE_W'(w) + PROBE_W'(1);
  endfunction

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    mem_req_valid = (state_q == ST_ISSUE);
    ev_accept     = req_valid && req_ready;
    ev_probe_fire = mem_req_valid && mem_req_ready;
    ev_probe_done = (state_q == ST_WAIT) && mem_rsp_valid;
    ev_last_way   = (way_q == WAY_W'(BUCKET_WAYS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      vpn_q      <= '0;
      base_q     <= '0;
      way_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_ppn    <= '0;
      rsp_prot   <= '0;
      rsp_probes <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ev_accept) begin
            vpn_q   <= req_vpn;
            base_q  <= req_base;
            way_q   <= '0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (ev_probe_fire) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ev_probe_done) begin
            if (hit || ev_last_way) begin
              rsp_valid  <= 1'b1;
              rsp_fault  <= !hit;
              rsp_ppn    <= hit ? hit_ppn : '0;
              rsp_prot   <= hit ? hit_prot : '0;
              rsp_probes <= probes_used(way_q);
              state_q    <= ST_IDLE;
            end else begin
              way_q   <= way_q + WAY_W'(1);
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PROT_W = 3,
  parameter int unsigned NBKT   = 64,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned BKT_W = $clog2(NBKT),
  localparam int unsigned PPN_W = BKT_W,
  localparam int unsigned IDX_W = BKT_W + WAY_W,
  localparam int unsigned ENT_W = 1 + VPN_W + PROT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [ADDR_W-1:0]  req_base,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENT_W-1:0]   mem_rsp_data,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [PPN_W-1:0]   rsp_ppn,
  output logic [PROT_W-1:0]  rsp_prot,
  output logic [PROBE_W-1:0] rsp_probes
);
  // internal events, named for the checker
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] base_q;
  logic [WAY_W-1:0]  way_q;
  logic              ev_accept;
  logic              ev_probe_fire;
  logic              ev_probe_done;
  logic              ev_last_way;
  logic [BKT_W-1:0]  cur_bkt;
  logic [IDX_W-1:0]  cur_idx;
  logic [PPN_W-1:0]  cur_ppn;
  logic              ent_valid;
  logic [PROT_W-1:0] ent_prot;
  logic              ent_hit;

  hpt_hash #(
    .VPN_W (VPN_W),
    .NBKT  (NBKT),
    .ADDR_W(ADDR_W)
  ) u_hash (
    .vpn (vpn_q),
    .base(base_q),
    .way (way_q),
    .bkt (cur_bkt),
    .idx (cur_idx),
    .ppn (cur_ppn),
    .addr(mem_req_addr)
  );

  hpt_match #(
    .VPN_W (VPN_W),
    .PROT_W(PROT_W)
  ) u_match (
    .entry    (mem_rsp_data),
    .vpn      (vpn_q),
    .ent_valid(ent_valid),
    .ent_prot (ent_prot),
    .hit      (ent_hit)
  );

  hpt_ctrl #(
    .VPN_W (VPN_W),
    .PROT_W(PROT_W),
    .PPN_W (PPN_W),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vpn      (req_vpn),
    .req_base     (req_base),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .hit          (ent_hit),
    .hit_ppn      (cur_ppn),
    .hit_prot     (ent_prot),
    .req_ready    (req_ready),
    .mem_req_valid(mem_req_valid),
    .vpn_q        (vpn_q),
    .base_q       (base_q),
    .way_q        (way_q),
    .ev_accept    (ev_accept),
    .ev_probe_fire(ev_probe_fire),
    .ev_probe_done(ev_probe_done),
    .ev_last_way  (ev_last_way),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_ppn      (rsp_ppn),
    .rsp_prot     (rsp_prot),
    .rsp_probes   (rsp_probes)
  );

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PROT_W = 3,
  parameter int unsigned NBKT   = 64,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned BKT_W = $clog2(NBKT),
  localparam int unsigned ENT_W = 1 + VPN_W + PROT_W,
  localparam int unsigned HALF  = VPN_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [ENT_W-1:0]  mem_rsp_data,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [2:0]        rsp_probes,
  input logic [VPN_W-1:0]  vpn_q,
  input logic [ADDR_W-1:0] base_q,
  input logic [1:0]        way_q,
  input logic              ev_accept,
  input logic              ev_probe_fire,
  input logic              ev_probe_done
);
  logic [ADDR_W-1:0] exp_first;
  logic [ADDR_W-1:0] last_addr_q;
  logic              match_c;
  logic              hit_seen_q;
  logic              pending_q;

  always_comb begin
    logic [VPN_W-1:0] folded;
    folded    = (vpn_q >> HALF) ^ vpn_q;
    exp_first = base_q + (ADDR_W'(folded[BKT_W-1:0]) << 2);
    match_c   = mem_rsp_data[ENT_W-1] && (mem_rsp_data[ENT_W-2:PROT_W] == vpn_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_addr_q <= '0;
      hit_seen_q  <= 1'b0;
      pending_q   <= 1'b0;
    end else begin
      if (ev_probe_fire) last_addr_q <= mem_req_addr;
      if (ev_accept) hit_seen_q <= 1'b0;
      else if (ev_probe_done && match_c) hit_seen_q <= 1'b1;
      if (ev_accept) pending_q <= 1'b1;
      else if (rsp_valid) pending_q <= 1'b0;
    end
  end

  assert_busy_blocks_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);
  assert_no_req_while_reading_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  assert_first_probe_hashed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_probe_fire && way_q == 2'd0) |-> mem_req_addr == exp_first);
  assert_probes_consecutive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_probe_fire && way_q != 2'd0) |-> mem_req_addr == last_addr_q + ADDR_W'(1));
  assert_probe_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_probes >= 3'd1 && rsp_probes <= 3'd4));
  assert_fault_after_four_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_probes == 3'd4);
  assert_match_answers_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_probe_done && match_c) |=> (rsp_valid && !rsp_fault));
  assert_stop_after_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_seen_q |-> !mem_req_valid);
  assert_rsp_has_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> pending_q);
  assert_rsp_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_mem_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  assert_invalid_last_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_probe_done && !mem_rsp_data[ENT_W-1] && way_q == 2'd3) |=> (rsp_valid && rsp_fault));

  // req_valid is part of the observed handshake; keep it referenced
  logic unused_ok;
  assign unused_ok = req_valid;

endmodule

bind hpt_walker hpt_walker_chk #(
  .VPN_W (VPN_W),
  .PROT_W(PROT_W),
  .NBKT  (NBKT),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_data (mem_rsp_data),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_probes   (rsp_probes),
  .vpn_q        (vpn_q),
  .base_q       (base_q),
  .way_q        (way_q),
  .ev_accept    (ev_accept),
  .ev_probe_fire(ev_probe_fire),
  .ev_probe_done(ev_probe_done)
);

// File: tb/hpt_walker_bench.sv
`timescale 1ns/1ps
module hpt_walker_bench;
  localparam int VPN_W  = 20;
  localparam int PROT_W = 3;
  localparam int NBKT   = 64;
  localparam int ADDR_W = 12;
  localparam int ENT_W  = 1 + VPN_W + PROT_W;
  localparam int MEM_D  = 1 << ADDR_W;
  localparam int LAT    = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic req_ready;
  logic [VPN_W-1:0]  req_vpn;
  logic [ADDR_W-1:0] req_base;
  logic mem_req_valid;
  logic mem_req_ready;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [ENT_W-1:0] mem_rsp_data;
  logic rsp_valid;
  logic rsp_fault;
  logic [5:0] rsp_ppn;
  logic [PROT_W-1:0] rsp_prot;
  logic [2:0] rsp_probes;

  always #2 clk = ~clk;

  hpt_walker u_hpt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_base(req_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_ppn(rsp_ppn),
    .rsp_prot(rsp_prot), .rsp_probes(rsp_probes)
  );

  // ---------------- memory model ----------------
  logic [ENT_W-1:0]  mem [MEM_D];
  logic [ADDR_W-1:0] rd_log [MEM_D];
  int                nlog;
  logic              stall;
  logic              pend;
  logic [ADDR_W-1:0] pend_addr;
  int                cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      nlog <= 0; pend <= 1'b0; cnt <= 0; pend_addr <= '0;
      mem_rsp_valid <= 1'b0; mem_rsp_data <= '0; mem_req_ready <= 1'b1;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1'b1; pend_addr <= mem_req_addr; cnt <= LAT;
        rd_log[nlog] <= mem_req_addr; nlog <= nlog + 1;
      end else if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid <= 1'b1; mem_rsp_data <= mem[pend_addr]; pend <= 1'b0;
        end else cnt <= cnt - 1;
      end
      mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
    end
  end

  // ---------------- bookkeeping ----------------
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic       r_fault;
  logic [5:0] r_ppn;
  logic [2:0] r_prot;
  logic [2:0] r_probes;
  int         r_reads;
  int         r_extra;
  logic [ADDR_W-1:0] r_first;
  logic [ADDR_W-1:0] r_last;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_bucket(input logic [VPN_W-1:0] v);
    int hi, lo;
    hi = int'(v) / 1024;
    lo = int'(v) % 1024;
    return (hi ^ lo) % NBKT;
  endfunction

  function automatic logic [ENT_W-1:0] mk_ent(input bit v, input logic [VPN_W-1:0] t,
                                              input logic [PROT_W-1:0] p);
    return {v, t, p};
  endfunction

  task automatic clear_table(input int base);
    for (int i = 0; i < 4 * NBKT; i++) mem[base + i] = '0;
  endtask

  task automatic put(input int base, input int bkt, input int way, input logic [ENT_W-1:0] e);
    mem[base + bkt * 4 + way] = e;
  endtask

  task automatic run_lookup(input logic [VPN_W-1:0] vpn, input logic [ADDR_W-1:0] base);
    int start;
    int n;
    start = nlog;
    @(negedge clk);
    req_vpn = vpn; req_base = base; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_vpn = ~vpn; req_base = ~base;
    n = 0;
    while (!rsp_valid && n < 400) begin @(negedge clk); n++; end
    if (!rsp_valid) begin
      failures++;
      $display("FAIL R7 actual=no_response expected=response");
    end
    r_fault = rsp_fault; r_ppn = rsp_ppn; r_prot = rsp_prot; r_probes = rsp_probes;
    r_reads = nlog - start;
    r_first = rd_log[start];
    r_last  = rd_log[nlog - 1];
    r_extra = 0;
    repeat (4) begin @(negedge clk); if (rsp_valid) r_extra++; end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R10 req_ready", req_ready, 1);
    chk("R10 mem_req_valid", mem_req_valid, 0);
    chk("R10 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_first_hit;
    logic [VPN_W-1:0] v;
    int b;
    v = 20'h12345; b = exp_bucket(v);
    clear_table(12'h100);
    put(12'h100, b, 0, mk_ent(1'b1, v, 3'b101));
    run_lookup(v, 12'h100);
    chk("R2 first address", r_first, 12'h100 + b * 4);
    chk("R4 fault", r_fault, 0);
    chk("R4 ppn", r_ppn, (b * 4 + 0) / 4);
    chk("R4 prot", r_prot, 3'b101);
    chk("R4 probes", r_probes, 1);
    chk("R6 reads", r_reads, 1);
    chk("R7 extra responses", r_extra, 0);
  endtask

  task automatic t_collision(input int k, input string tagmsg);
    logic [VPN_W-1:0] v;
    int b;
    v = 20'h0ABCD + 20'(k * 7); b = exp_bucket(v);
    clear_table(12'h200);
    for (int w = 0; w < k; w++) put(12'h200, b, w, mk_ent(1'b1, v ^ 20'h80000 ^ 20'(w), 3'b000));
    put(12'h200, b, k, mk_ent(1'b1, v, 3'(k + 1)));
    put(12'h200, b, 3 - (k == 3 ? 0 : 0), mem[12'h200 + b * 4 + 3]);
    run_lookup(v, 12'h200);
    chk({tagmsg, " R3 reads"}, r_reads, k + 1);
    chk({tagmsg, " R3 last address"}, r_last, r_first + k);
    chk({tagmsg, " R2 first address"}, r_first, 12'h200 + b * 4);
    chk({tagmsg, " R4 probes"}, r_probes, k + 1);
    chk({tagmsg, " R4 ppn"}, r_ppn, (b * 4 + k) / 4);
    chk({tagmsg, " R4 prot"}, r_prot, k + 1);
    chk({tagmsg, " R4 fault"}, r_fault, 0);
  endtask

  task automatic t_fault;
    logic [VPN_W-1:0] v;
    int b;
    v = 20'h3C0F1; b = exp_bucket(v);
    clear_table(12'h080);
    for (int w = 0; w < 4; w++) put(12'h080, b, w, mk_ent(1'b1, v ^ 20'(w + 1), 3'b111));
    run_lookup(v, 12'h080);
    chk("R5 fault", r_fault, 1);
    chk("R5 probes", r_probes, 4);
    chk("R5 ppn", r_ppn, 0);
    chk("R5 prot", r_prot, 0);
    chk("R5 reads", r_reads, 4);
  endtask

  task automatic t_invalid_tag;
    logic [VPN_W-1:0] v;
    int b;
    v = 20'h00777; b = exp_bucket(v);
    clear_table(12'h300);
    put(12'h300, b, 0, mk_ent(1'b0, v, 3'b001));
    put(12'h300, b, 1, mk_ent(1'b1, v, 3'b010));
    run_lookup(v, 12'h300);
    chk("R9 skip invalid probes", r_probes, 2);
    chk("R9 prot from valid entry", r_prot, 3'b010);
    clear_table(12'h300);
    for (int w = 0; w < 4; w++) put(12'h300, b, w, mk_ent(1'b0, v, 3'b011));
    run_lookup(v, 12'h300);
    chk("R9 all invalid fault", r_fault, 1);
    chk("R9 all invalid probes", r_probes, 4);
  endtask

  task automatic t_stall;
    stall = 1'b1;
    t_collision(2, "stalled");
    stall = 1'b0;
    chk("R8 stalled reads", r_reads, 3);
  endtask

  task automatic t_busy_ignore;
    logic [VPN_W-1:0] v;
    int b;
    int n;
    int start;
    v = 20'h5A5A5; b = exp_bucket(v);
    clear_table(12'h400);
    put(12'h400, b, 0, mk_ent(1'b1, v, 3'b110));
    start = nlog;
    @(negedge clk);
    req_vpn = v; req_base = 12'h400; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_vpn = 20'h00001; req_base = 12'h000;   // request still offered while busy
    chk("R1 ready low while busy", req_ready, 0);
    @(negedge clk);
    chk("R1 ready low while busy later", req_ready, 0);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 400) begin @(negedge clk); n++; end
    chk("R11 hit with captured vpn", rsp_fault, 0);
    chk("R11 prot", rsp_prot, 3'b110);
    chk("R11 captured base", rd_log[start], 12'h400 + b * 4);
    repeat (4) @(negedge clk);
    chk("R7 held request not re-accepted", nlog - start, 1);
  endtask

  task automatic t_hash_edges;
    clear_table(12'h000);
    put(12'h000, 0, 0, mk_ent(1'b1, 20'hFFFFF, 3'b001));
    run_lookup(20'hFFFFF, 12'h000);
    chk("R2 folded to bucket 0", r_first, 0);
    chk("R4 ppn bucket 0", r_ppn, 0);
    put(12'h000, 63, 0, mk_ent(1'b1, 20'h0003F, 3'b010));
    run_lookup(20'h0003F, 12'h000);
    chk("R2 last bucket address", r_first, 63 * 4);
    chk("R4 ppn last bucket", r_ppn, 63);
    put(12'h000, exp_bucket(20'hFFC3F), 0, mk_ent(1'b1, 20'hFFC3F, 3'b100));
    run_lookup(20'hFFC3F, 12'h000);
    chk("R2 upper half folded", r_first, exp_bucket(20'hFFC3F) * 4);
  endtask

  // ---------------- main ----------------
  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vpn = '0; req_base = '0; stall = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_hit();
    t_collision(1, "way1");
    t_collision(2, "way2");
    t_collision(3, "way3");
    t_fault();
    t_invalid_tag();
    t_stall();
    t_busy_ignore();
    t_hash_edges();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule